// File: doc/BRIEF.md
# UART Command Word Decoder

This block sits behind the command register of a serial port. Software writes one 32-bit word at a time. The block turns each word into control for a receiver and a transmitter. One word carries three fields that act independently of one another:

- **Enable field.** Four low bits that switch each direction on or off.
- **Channel command.** A 5-bit code whose bits are not adjacent in the word.
- **General command.** A 3-bit code.

Most commands leave the block as a pulse that lasts exactly one clock. A few leave it as sticky levels that hold until the opposing command arrives: the two direction enables, break, stale-event enable and command protection.

A write is presented as a single-cycle strobe together with the data word. There is no back-pressure: every strobed word is taken in the cycle it is presented. All outputs are registered. Pulses and level changes appear in the clock cycle that follows the strobed edge. Control pins are plain levels, and there is no streaming payload.

Top module: `uart_cmd_decoder`

## Requirements
- R1: After reset, both direction enables, break, stale-event enable and command protection are 0, and every pulse output is 0.
- R2: Bit 0 enables the receiver and bit 1 disables it; bit 2 enables the transmitter and bit 3 disables it. When both bits for one direction are set, disable wins. A direction with neither bit set keeps its state.
- R3: The channel command code is {data[11], data[7:4]}, with data[11] as its most significant bit.
- R4: Each of the following channel codes gives a one-cycle pulse on its own output in the cycle after the write: 1 receiver reset, 2 transmitter reset, 3 error-status reset, 4 break-change interrupt clear, 7 CTS-delta clear, 8 stale interrupt clear, 13 RFR assert, 14 RFR release, 16 TX-error clear, 17 TX-done clear.
- R5: Channel code 5 sets the break level and channel code 6 clears it. The level holds between these commands.
- R6: The general command code is data[10:8]. Code 3 pulses the TX-ready clear output and code 4 pulses the forced-stale output, each for one cycle.
- R7: General codes 5 and 6 set and clear the stale-event enable level. General codes 1 and 2 set and clear the command-protection level.
- R8: A channel or general code of 0 does nothing, and neither does any code not listed above (channel 9–12, 15, 18–31; general 7).
- R9: The enable field, the channel command and the general command of one write all take effect together in the same cycle.
- R10: In a cycle with no write strobe, every pulse output is 0 and every level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word |
| rx_enable | output | 1 | Receiver enable level |
| tx_enable | output | 1 | Transmitter enable level |
| rx_reset_p | output | 1 | Receiver reset pulse |
| tx_reset_p | output | 1 | Transmitter reset pulse |
| err_reset_p | output | 1 | Error-status reset pulse |
| brk_chg_clr_p | output | 1 | Break-change interrupt clear pulse |
| cts_delta_clr_p | output | 1 | CTS-delta clear pulse |
| stale_clr_p | output | 1 | Stale interrupt clear pulse |
| rfr_assert_p | output | 1 | Ready-for-receiving assert pulse |
| rfr_release_p | output | 1 | Ready-for-receiving release pulse |
| tx_err_clr_p | output | 1 | TX-error clear pulse |
| tx_done_clr_p | output | 1 | TX-done clear pulse |
| break_on | output | 1 | Break level |
| tx_ready_clr_p | output | 1 | TX-ready clear pulse |
| stale_force_p | output | 1 | Forced-stale pulse |
| stale_evt_on | output | 1 | Stale-event enable level |
| cmd_protect | output | 1 | Command-protection level |

## Verification
The channel decoder and the general decoder read disjoint bits of the same word, so one write can fire a channel pulse and a general pulse together. The same write can also flip a direction enable. The bench provokes this with words that combine all three fields, for example a receiver reset with a stale-event enable and a receiver enable, or a break start with forced stale and a conflicting enable/disable pair. It judges each output against a model of each field on its own, so an action that one field masks in another shows up as a mismatch. Every write in the channel and general sweeps is also checked for silence on the other field's outputs.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  localparam int CMD_W      = 32;
  localparam int NDIR       = 2;
  localparam int CH_LO_LSB  = 4;
  localparam int CH_LO_W    = 4;
  localparam int CH_HI_BIT  = 11;
  localparam int CH_W       = CH_LO_W + 1;
  localparam int GEN_LSB    = 8;
  localparam int GEN_W      = 3;
  localparam int USED_TOP   = CH_HI_BIT;

  typedef enum logic [CH_W-1:0] {
    CH_NULL       = 5'd0,
    CH_RST_RX     = 5'd1,
    CH_RST_TX     = 5'd2,
    CH_RST_ERR    = 5'd3,
    CH_CLR_BRKCHG = 5'd4,
    CH_BRK_START  = 5'd5,
    CH_BRK_STOP   = 5'd6,
    CH_CLR_CTS    = 5'd7,
    CH_CLR_STALE  = 5'd8,
    CH_RFR_SET    = 5'd13,
    CH_RFR_CLR    = 5'd14,
    CH_CLR_TXERR  = 5'd16,
    CH_CLR_TXDONE = 5'd17
  } chan_cmd_e;

  typedef enum logic [GEN_W-1:0] {
    GC_NULL      = 3'd0,
    GC_PROT_ON   = 3'd1,
    GC_PROT_OFF  = 3'd2,
    GC_CLR_TXRDY = 3'd3,
    GC_FORCE_STL = 3'd4,
    GC_STL_ON    = 3'd5,
    GC_STL_OFF   = 3'd6
  } gen_cmd_e;

  typedef struct packed {
    logic [NDIR-1:0] on;
    logic [NDIR-1:0] off;
    logic [CH_W-1:0]  chan;
    logic [GEN_W-1:0] gen;
    logic             valid;
  } cmd_fields_t;

  typedef struct packed {
    logic rst_rx;
    logic rst_tx;
    logic rst_err;
    logic clr_brkchg;
    logic clr_cts;
    logic clr_stale;
    logic rfr_set;
    logic rfr_clr;
    logic clr_txerr;
    logic clr_txdone;
  } chan_pulse_t;
endpackage

// File: rtl/uart_cmd_split.sv
module uart_cmd_split
  import uart_cmd_pkg::*;
(
  input  logic             we,
  input  logic [CMD_W-1:0] data,
  output cmd_fields_t      fields
);
  logic unused_upper;
  assign unused_upper = ^data[CMD_W-1:USED_TOP+1];

  // enable field: bit 2*i turns direction i on, bit 2*i+1 turns it off
  for (genvar i = 0; i < NDIR; i++) begin : g_dir
    assign fields.on[i]  = data[2*i];
    assign fields.off[i] = data[2*i+1];
  end

  assign fields.chan  = {data[CH_HI_BIT], data[CH_LO_LSB +: CH_LO_W]};
  assign fields.gen   = data[GEN_LSB +: GEN_W];
  assign fields.valid = we;
endmodule

// File: rtl/uart_cmd_enable.sv
module uart_cmd_enable
  import uart_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [NDIR-1:0] on,
  input  logic [NDIR-1:0] off,
  output logic [NDIR-1:0] en
);
  for (genvar i = 0; i < NDIR; i++) begin : g_en
    logic en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 en_q <= 1'b0;
      else if (valid && off[i])   en_q <= 1'b0;
      else if (valid && on[i])    en_q <= 1'b1;
    end
    assign en[i] = en_q;

    a_r2_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && off[i]) |=> !en[i]);
    a_r2_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && on[i] && !off[i]) |=> en[i]);
    a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(en[i]));
  end
endmodule

// File: rtl/uart_cmd_chan.sv
module uart_cmd_chan
  import uart_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [CH_W-1:0] chan,
  output chan_pulse_t     pulses,
  output logic            brk
);
  chan_pulse_t pulse_q;
  logic        brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      brk_q   <= 1'b0;
    end else begin
      pulse_q <= '0;
      if (valid) begin
        case (chan)
          CH_RST_RX:     pulse_q.rst_rx     <= 1'b1;
          CH_RST_TX:     pulse_q.rst_tx     <= 1'b1;
          CH_RST_ERR:    pulse_q.rst_err    <= 1'b1;
          CH_CLR_BRKCHG: pulse_q.clr_brkchg <= 1'b1;
          CH_BRK_START:  brk_q              <= 1'b1;
          CH_BRK_STOP:   brk_q              <= 1'b0;
          CH_CLR_CTS:    pulse_q.clr_cts    <= 1'b1;
          CH_CLR_STALE:  pulse_q.clr_stale  <= 1'b1;
          CH_RFR_SET:    pulse_q.rfr_set    <= 1'b1;
          CH_RFR_CLR:    pulse_q.rfr_clr    <= 1'b1;
          CH_CLR_TXERR:  pulse_q.clr_txerr  <= 1'b1;
          CH_CLR_TXDONE: pulse_q.clr_txdone <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign pulses = pulse_q;
  assign brk    = brk_q;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));
  a_r4_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |-> $past(valid));
  a_r5_break_set: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && chan == CH_BRK_START) |=> brk);
  a_r5_break_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && chan == CH_BRK_STOP) |=> !brk);
  a_r8_null_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && chan == CH_NULL) |=> (pulses == '0 && $stable(brk)));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (pulses == '0 && $stable(brk)));
endmodule

// File: rtl/uart_cmd_gen.sv
module uart_cmd_gen
  import uart_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [GEN_W-1:0] gen,
  output logic             clr_txrdy,
  output logic             force_stale,
  output logic             stale_en,
  output logic             prot
);
  logic txrdy_q, force_q, stale_q, prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txrdy_q <= 1'b0;
      force_q <= 1'b0;
      stale_q <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      txrdy_q <= 1'b0;
      force_q <= 1'b0;
      if (valid) begin
        case (gen)
          GC_PROT_ON:   prot_q  <= 1'b1;
          GC_PROT_OFF:  prot_q  <= 1'b0;
          GC_CLR_TXRDY: txrdy_q <= 1'b1;
          GC_FORCE_STL: force_q <= 1'b1;
          GC_STL_ON:    stale_q <= 1'b1;
          GC_STL_OFF:   stale_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign clr_txrdy   = txrdy_q;
  assign force_stale = force_q;
  assign stale_en    = stale_q;
  assign prot        = prot_q;

  a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_txrdy && force_stale));
  a_r6_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_txrdy || force_stale) |-> $past(valid));
  a_r7_stale_set: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && gen == GC_STL_ON) |=> stale_en);
  a_r7_prot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && gen == GC_PROT_OFF) |=> !prot);
  a_r10_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(stale_en) && $stable(prot) && !clr_txrdy && !force_stale));
endmodule

// File: rtl/uart_cmd_decoder.sv
module uart_cmd_decoder
  import uart_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic             rx_enable,
  output logic             tx_enable,
  output logic             rx_reset_p,
  output logic             tx_reset_p,
  output logic             err_reset_p,
  output logic             brk_chg_clr_p,
  output logic             cts_delta_clr_p,
  output logic             stale_clr_p,
  output logic             rfr_assert_p,
  output logic             rfr_release_p,
  output logic             tx_err_clr_p,
  output logic             tx_done_clr_p,
  output logic             break_on,
  output logic             tx_ready_clr_p,
  output logic             stale_force_p,
  output logic             stale_evt_on,
  output logic             cmd_protect
);
  cmd_fields_t     fld;
  chan_pulse_t     cp;
  logic [NDIR-1:0] en;

  uart_cmd_split u_split (
    .we     (cmd_we),
    .data   (cmd_wdata),
    .fields (fld)
  );

  uart_cmd_enable u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (fld.valid),
    .on    (fld.on),
    .off   (fld.off),
    .en    (en)
  );

  uart_cmd_chan u_chan (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid  (fld.valid),
    .chan   (fld.chan),
    .pulses (cp),
    .brk    (break_on)
  );

  uart_cmd_gen u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (fld.valid),
    .gen         (fld.gen),
    .clr_txrdy   (tx_ready_clr_p),
    .force_stale (stale_force_p),
    .stale_en    (stale_evt_on),
    .prot        (cmd_protect)
  );

  assign rx_enable       = en[0];
  assign tx_enable       = en[1];
  assign rx_reset_p      = cp.rst_rx;
  assign tx_reset_p      = cp.rst_tx;
  assign err_reset_p     = cp.rst_err;
  assign brk_chg_clr_p   = cp.clr_brkchg;
  assign cts_delta_clr_p = cp.clr_cts;
  assign stale_clr_p     = cp.clr_stale;
  assign rfr_assert_p    = cp.rfr_set;
  assign rfr_release_p   = cp.rfr_clr;
  assign tx_err_clr_p    = cp.clr_txerr;
  assign tx_done_clr_p   = cp.clr_txdone;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_enable && !tx_enable && !break_on && !stale_evt_on && !cmd_protect));
  a_r9_fields_together: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_wdata[1:0] == 2'b01 && cmd_wdata[7:4] == 4'd1 && !cmd_wdata[11]
     && cmd_wdata[10:8] == 3'd5) |=> (rx_enable && rx_reset_p && stale_evt_on));
endmodule

// File: tb/uart_cmd_decoder_bench.sv
module uart_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic rx_enable, tx_enable, rx_reset_p, tx_reset_p, err_reset_p, brk_chg_clr_p;
  logic cts_delta_clr_p, stale_clr_p, rfr_assert_p, rfr_release_p, tx_err_clr_p;
  logic tx_done_clr_p, break_on, tx_ready_clr_p, stale_force_p, stale_evt_on, cmd_protect;

  int n_chk = 0;
  int n_bad = 0;
  logic m_rx = 0, m_tx = 0, m_brk = 0, m_stl = 0, m_prot = 0;

  always #10 clk = ~clk;

  uart_cmd_decoder u_uart_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .rx_reset_p(rx_reset_p),
    .tx_reset_p(tx_reset_p), .err_reset_p(err_reset_p), .brk_chg_clr_p(brk_chg_clr_p),
    .cts_delta_clr_p(cts_delta_clr_p), .stale_clr_p(stale_clr_p),
    .rfr_assert_p(rfr_assert_p), .rfr_release_p(rfr_release_p),
    .tx_err_clr_p(tx_err_clr_p), .tx_done_clr_p(tx_done_clr_p), .break_on(break_on),
    .tx_ready_clr_p(tx_ready_clr_p), .stale_force_p(stale_force_p),
    .stale_evt_on(stale_evt_on), .cmd_protect(cmd_protect)
  );

  function automatic logic [9:0] chan_p();
    return {rx_reset_p, tx_reset_p, err_reset_p, brk_chg_clr_p, cts_delta_clr_p,
            stale_clr_p, rfr_assert_p, rfr_release_p, tx_err_clr_p, tx_done_clr_p};
  endfunction

  function automatic logic [9:0] exp_chan(input logic [4:0] c);
    case (c)
      5'd1:  return 10'b10_0000_0000;
      5'd2:  return 10'b01_0000_0000;
      5'd3:  return 10'b00_1000_0000;
      5'd4:  return 10'b00_0100_0000;
      5'd7:  return 10'b00_0010_0000;
      5'd8:  return 10'b00_0001_0000;
      5'd13: return 10'b00_0000_1000;
      5'd14: return 10'b00_0000_0100;
      5'd16: return 10'b00_0000_0010;
      5'd17: return 10'b00_0000_0001;
      default: return 10'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] c, input logic [2:0] g, input logic [3:0] e);
    return {20'b0, c[4], g, c[3:0], e};
  endfunction

  // One write, then full comparison of every output against the field model
  task automatic wr(input logic [31:0] d, input string tag);
    logic [4:0] c;
    logic [2:0] g;
    c = {d[11], d[7:4]};
    g = d[10:8];
    if (d[1]) m_rx = 0; else if (d[0]) m_rx = 1;
    if (d[3]) m_tx = 0; else if (d[2]) m_tx = 1;
    if (c == 5'd5) m_brk = 1; else if (c == 5'd6) m_brk = 0;
    if (g == 3'd5) m_stl = 1; else if (g == 3'd6) m_stl = 0;
    if (g == 3'd1) m_prot = 1; else if (g == 3'd2) m_prot = 0;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = d;
    @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
    chk("R3/R4/R8 chan pulse", tag, 32'(chan_p()), 32'(exp_chan(c)));
    chk("R6/R8 gen pulse", tag, {30'b0, tx_ready_clr_p, stale_force_p}, {30'b0, g == 3'd3, g == 3'd4});
    chk("R2 enables", tag, {30'b0, rx_enable, tx_enable}, {30'b0, m_rx, m_tx});
    chk("R5 break", tag, 32'(break_on), 32'(m_brk));
    chk("R7 stale/prot", tag, {30'b0, stale_evt_on, cmd_protect}, {30'b0, m_stl, m_prot});
    @(negedge clk);
    chk("R10 idle pulses", tag, {20'b0, chan_p(), tx_ready_clr_p, stale_force_p}, 32'b0);
    chk("R10 idle levels", tag, {27'b0, rx_enable, tx_enable, break_on, stale_evt_on, cmd_protect},
        {27'b0, m_rx, m_tx, m_brk, m_stl, m_prot});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset levels", "after reset",
        {27'b0, rx_enable, tx_enable, break_on, stale_evt_on, cmd_protect}, 32'b0);
    chk("R1 reset pulses", "after reset", {20'b0, chan_p(), tx_ready_clr_p, stale_force_p}, 32'b0);
  endtask

  task automatic t_enables();
    wr(mk(0, 0, 4'b0001), "R2 rx on");
    wr(mk(0, 0, 4'b0100), "R2 tx on");
    wr(mk(0, 0, 4'b0000), "R2 none keeps");
    wr(mk(0, 0, 4'b0011), "R2 rx both, off wins");
    wr(mk(0, 0, 4'b1101), "R2 tx both, rx on");
    wr(mk(0, 0, 4'b0110), "R2 rx off tx on");
  endtask

  task automatic t_chan_sweep();
    for (int k = 0; k < 32; k++) wr(mk(5'(k), 0, 4'b0), "R3 R4 R8 chan sweep");
  endtask

  task automatic t_gen_sweep();
    for (int k = 0; k < 8; k++) wr(mk(0, 3'(k), 4'b0), "R6 R7 R8 gen sweep");
    wr(mk(0, 3'd1, 4'b0), "R7 prot on");
    wr(mk(0, 3'd5, 4'b0), "R7 stale on");
    wr(mk(0, 3'd7, 4'b0), "R8 gen 7 no action");
    wr(mk(0, 3'd6, 4'b0), "R7 stale off");
  endtask

  task automatic t_break();
    wr(mk(5'd5, 0, 4'b0), "R5 start");
    wr(mk(5'd9, 0, 4'b0), "R5 hold via unlisted");
    wr(mk(5'd5, 0, 4'b0), "R5 start again");
    wr(mk(5'd6, 0, 4'b0), "R5 stop");
  endtask

  task automatic t_concurrent();
    wr(mk(5'd1, 3'd5, 4'b0001), "R9 rx reset + stale on + rx on");
    wr(mk(5'd5, 3'd4, 4'b1110), "R9 break + force stale + tx conflict");
    wr(mk(5'd17, 3'd3, 4'b0111), "R9 tx-done + tx-ready clear");
    wr(mk(5'd16, 3'd2, 4'b1000), "R9 tx-err + prot off");
    wr(mk(5'd6, 3'd6, 4'b0010), "R9 stop + stale off + rx off");
  endtask

  task automatic t_idle();
    repeat (5) @(negedge clk);
    chk("R10 long idle", "no strobe", {20'b0, chan_p(), tx_ready_clr_p, stale_force_p}, 32'b0);
  endtask

  initial begin
    t_reset();
    t_enables();
    t_chan_sweep();
    t_gen_sweep();
    t_break();
    t_concurrent();
    t_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule